// File: doc/BRIEF.md
# Clock-Stop Monitor and Power Sequencer

This block is the digital power-state controller of a multi-channel converter. A free-running reference clock measures a sampled copy of the conversion clock. When that clock stalls or slows too far, the controller drops the converter into a partial power-down and keeps the ready flag low until a recovery interval has passed. The length of that interval depends on how long the clock was gone. A brief hiccup costs a short wait. A real stop costs a longer one.

A full power-down pin overrides everything else. While it is high, the reference, clock and channel enables are all off. After it is released, the longest recovery interval runs before ready returns. A per-channel power-down register turns off single channels while the rest stay on. A functional reset clears that register and zeroes the output data. It leaves the clock enable alone.

Every interval is a counter on the reference clock. Its limit comes from the reference frequency and a time parameter.

Top module: `pwrseq_top`

## Requirements
- R1: If no rising edge of `convClk` is seen for 15 reference cycles (300 ns at 50 MHz), the block enters partial power-down within a few cycles. In that state `clkEn` is 0, `chanEn` is all zero, `refEn` stays 1 and `ready` is 0.
- R2: A conversion clock with a period of 400 ns (below 3 MHz) counts as stopped. `ready` stays 0 for as long as that slow clock persists.
- R3: A gap between rising edges of more than 10 and fewer than 15 reference cycles is a momentary stop. `ready` drops, `clkEn` stays 1, and `ready` returns 500 reference cycles (10 µs) after the gap ends.
- R4: After partial power-down, the first conversion-clock edge starts a recovery of 5000 reference cycles (100 µs). Ready is 0 during it and 1 after it.
- R5: While `pdPin` is high, `refEn`, `clkEn` and every `chanEn` bit are 0 and `ready` is 0. After `pdPin` falls, `ready` returns 25000 reference cycles (500 µs) later. The same interval follows `arstN`.
- R6: A `pdPin` pulse during a short or long recovery cancels it. The full 25000-cycle interval restarts from the release of `pdPin`.
- R7: A cycle with `chanWe` high loads `chanPdIn` into the channel power-down register. Bit i set to 1 forces `chanEn[i]` to 0 from the next cycle, while the other enabled channels stay 1.
- R8: While `rstReq` is high, `zeroData` is 1 and the channel power-down register is cleared to 0 (all channels enabled). `clkEn` and `ready` are not affected by `rstReq`.
- R9: `zeroData` is 1 whenever `ready` is 0, and 0 when `ready` is 1 and `rstReq` is 0.
- R10: While `arstN` is low, `ready` is 0, `zeroData` is 1, `refEn` is 1 and `chanEn` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| arstN | input | 1 | Asynchronous power-on reset, active low |
| rstReq | input | 1 | Functional reset request, active high |
| pdPin | input | 1 | Full power-down request, asynchronous |
| convClk | input | 1 | Monitored conversion clock, asynchronous |
| chanWe | input | 1 | Write strobe for the channel power-down register |
| chanPdIn | input | NUM_CH | Channel power-down bits to load (1 = off) |
| refEn | output | 1 | Reference circuitry enable |
| clkEn | output | 1 | Clock circuitry enable |
| chanEn | output | NUM_CH | Per-channel enables |
| ready | output | 1 | Converter output is valid |
| zeroData | output | 1 | Force output data to zero code |

## Verification
The hardest situation to create is a gap that is longer than normal but shorter than the stop limit. Only that window selects the 10 µs recovery instead of the 100 µs one. The bench's conversion-clock generator can insert a fixed pause after a falling edge. This gives one edge-to-edge gap of 240 ns, which sits between the two thresholds even with a cycle of synchronizer uncertainty. A slower clock period is used to show that a slow clock re-enters power-down over and over. A power-down pulse dropped into the middle of a long recovery shows that the full interval restarts.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [2:0] {
    ST_FULL_PD,
    ST_FULL_REC,
    ST_PARTIAL,
    ST_LONG_REC,
    ST_SHORT_REC,
    ST_ACTIVE
  } pwrState_t;

  typedef enum logic [1:0] {
    REC_SHORT,
    REC_LONG,
    REC_FULL
  } recSel_t;

  typedef struct packed {
    logic    recClr;
    recSel_t recSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge arstN)
          if (!arstN) chain[0] <= 1'b0;
          else        chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge arstN)
          if (!arstN) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pwrseq_datapath.sv
module pwrseq_datapath
  import pwrseq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STOP_CYC    = 15,
  parameter int HICCUP_CYC  = 10,
  parameter int SHORT_CYC   = 500,
  parameter int LONG_CYC    = 5000,
  parameter int FULL_CYC    = 25000
) (
  input  logic        clk,
  input  logic        arstN,
  input  logic        convClk,
  input  logic        pdPin,
  input  ctrlStrobe_t strobe,
  output logic        convEdge,
  output logic        stopped,
  output logic        hiccup,
  output logic        pdSync,
  output logic        recDone
);
  localparam int GW = $clog2(STOP_CYC + 1);
  localparam int RW = $clog2(FULL_CYC + 1);
  localparam logic [GW-1:0] GAP_MAX    = GW'(STOP_CYC);
  localparam logic [GW-1:0] GAP_HICCUP = GW'(HICCUP_CYC);
  localparam logic [RW-1:0] LIM_SHORT  = RW'(SHORT_CYC - 1);
  localparam logic [RW-1:0] LIM_LONG   = RW'(LONG_CYC - 1);
  localparam logic [RW-1:0] LIM_FULL   = RW'(FULL_CYC - 1);

  logic convSync, convPrev;
  logic [GW-1:0] gapCnt;
  logic [RW-1:0] recCnt, recLim;

  pwrseq_sync #(.STAGES(SYNC_STAGES)) uConvSync (
    .clk(clk), .arstN(arstN), .d(convClk), .q(convSync));
  pwrseq_sync #(.STAGES(SYNC_STAGES)) uPdSync (
    .clk(clk), .arstN(arstN), .d(pdPin), .q(pdSync));

  always_ff @(posedge clk or negedge arstN)
    if (!arstN) convPrev <= 1'b0;
    else        convPrev <= convSync;

  assign convEdge = convSync & ~convPrev;

  // cycles since the last rising edge, saturating at the stop limit
  always_ff @(posedge clk or negedge arstN)
    if (!arstN)                gapCnt <= '0;
    else if (convEdge)         gapCnt <= '0;
    else if (gapCnt != GAP_MAX) gapCnt <= gapCnt + 1'b1;

  assign stopped = (gapCnt == GAP_MAX);
  assign hiccup  = convEdge && !stopped && (gapCnt >= GAP_HICCUP);

  always_comb
    case (strobe.recSel)
      REC_SHORT: recLim = LIM_SHORT;
      REC_LONG:  recLim = LIM_LONG;
      default:   recLim = LIM_FULL;
    endcase

  always_ff @(posedge clk or negedge arstN)
    if (!arstN)                      recCnt <= '0;
    else if (strobe.recClr)          recCnt <= '0;
    else if (recCnt != LIM_FULL)     recCnt <= recCnt + 1'b1;

  assign recDone = (recCnt >= recLim);

  p_gap_sat_r1: assert property (@(posedge clk) disable iff (!arstN)
    gapCnt <= GAP_MAX);

  p_edge_clears_gap_r2: assert property (@(posedge clk) disable iff (!arstN)
    convEdge |=> (gapCnt == '0));

endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
  import pwrseq_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              arstN,
  input  logic              rstReq,
  input  logic              chanWe,
  input  logic [NUM_CH-1:0] chanPdIn,
  input  logic              convEdge,
  input  logic              stopped,
  input  logic              hiccup,
  input  logic              pdSync,
  input  logic              recDone,
  output ctrlStrobe_t       strobe,
  output logic              refEn,
  output logic              clkEn,
  output logic [NUM_CH-1:0] chanEn,
  output logic              ready,
  output logic              zeroData
);
  pwrState_t state, nextState;
  logic restart, inRec;
  logic [NUM_CH-1:0] chanPd;

  always_comb begin
    nextState = state;
    restart   = 1'b0;
    if (pdSync) begin
      nextState = ST_FULL_PD;
      restart   = 1'b1;
    end else begin
      case (state)
        ST_FULL_PD: begin
          nextState = ST_FULL_REC;
          restart   = 1'b1;
        end
        ST_FULL_REC, ST_LONG_REC: begin
          if (stopped && !convEdge) nextState = ST_PARTIAL;
          else if (recDone)         nextState = ST_ACTIVE;
        end
        ST_PARTIAL: begin
          if (convEdge) begin
            nextState = ST_LONG_REC;
            restart   = 1'b1;
          end
        end
        ST_SHORT_REC: begin
          if (stopped && !convEdge) nextState = ST_PARTIAL;
          else if (hiccup)          restart   = 1'b1;
          else if (recDone)         nextState = ST_ACTIVE;
        end
        ST_ACTIVE: begin
          if (stopped && !convEdge) nextState = ST_PARTIAL;
          else if (hiccup) begin
            nextState = ST_SHORT_REC;
            restart   = 1'b1;
          end
        end
        default: nextState = ST_FULL_PD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge arstN)
    if (!arstN) state <= ST_FULL_REC;
    else        state <= nextState;

  assign inRec = (state == ST_FULL_REC) || (state == ST_LONG_REC) ||
                 (state == ST_SHORT_REC);

  always_comb begin
    strobe.recClr = restart || !inRec;
    case (state)
      ST_SHORT_REC: strobe.recSel = REC_SHORT;
      ST_LONG_REC:  strobe.recSel = REC_LONG;
      default:      strobe.recSel = REC_FULL;
    endcase
  end

  always_ff @(posedge clk or negedge arstN)
    if (!arstN)      chanPd <= '0;
    else if (rstReq) chanPd <= '0;
    else if (chanWe) chanPd <= chanPdIn;

  assign refEn    = (state != ST_FULL_PD);
  assign clkEn    = (state != ST_FULL_PD) && (state != ST_PARTIAL);
  assign chanEn   = clkEn ? ~chanPd : '0;
  assign ready    = (state == ST_ACTIVE);
  assign zeroData = rstReq || !ready;

  p_stop_enter_r1: assert property (@(posedge clk) disable iff (!arstN)
    (stopped && !convEdge && !pdSync && state != ST_FULL_PD) |=> (state == ST_PARTIAL));

  p_pd_off_r5: assert property (@(posedge clk) disable iff (!arstN)
    pdSync |=> (!refEn && !clkEn && chanEn == '0 && !ready));

  p_ready_after_done_r3: assert property (@(posedge clk) disable iff (!arstN)
    $rose(ready) |-> $past(recDone));

  p_rst_clear_r8: assert property (@(posedge clk) disable iff (!arstN)
    rstReq |=> (chanPd == '0));

  p_part_exit_r4: assert property (@(posedge clk) disable iff (!arstN)
    (state == ST_PARTIAL && convEdge && !pdSync) |=> (state == ST_LONG_REC));

endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top
  import pwrseq_pkg::*;
#(
  parameter int REF_HZ      = 50_000_000,
  parameter int NUM_CH      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int STOP_NS     = 300,
  parameter int HICCUP_NS   = 200,
  parameter int SHORT_US    = 10,
  parameter int LONG_US     = 100,
  parameter int FULL_US     = 500
) (
  input  logic              clk,
  input  logic              arstN,
  input  logic              rstReq,
  input  logic              pdPin,
  input  logic              convClk,
  input  logic              chanWe,
  input  logic [NUM_CH-1:0] chanPdIn,
  output logic              refEn,
  output logic              clkEn,
  output logic [NUM_CH-1:0] chanEn,
  output logic              ready,
  output logic              zeroData
);
  localparam int CYC_PER_US = REF_HZ / 1_000_000;
  localparam int STOP_CYC   = CYC_PER_US * STOP_NS / 1000;
  localparam int HICCUP_CYC = CYC_PER_US * HICCUP_NS / 1000;
  localparam int SHORT_CYC  = CYC_PER_US * SHORT_US;
  localparam int LONG_CYC   = CYC_PER_US * LONG_US;
  localparam int FULL_CYC   = CYC_PER_US * FULL_US;

  ctrlStrobe_t strobe;
  logic convEdge, stopped, hiccup, pdSync, recDone;

  pwrseq_datapath #(
    .SYNC_STAGES(SYNC_STAGES), .STOP_CYC(STOP_CYC), .HICCUP_CYC(HICCUP_CYC),
    .SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC), .FULL_CYC(FULL_CYC)
  ) uData (
    .clk(clk), .arstN(arstN), .convClk(convClk), .pdPin(pdPin),
    .strobe(strobe), .convEdge(convEdge), .stopped(stopped),
    .hiccup(hiccup), .pdSync(pdSync), .recDone(recDone)
  );

  pwrseq_ctrl #(.NUM_CH(NUM_CH)) uCtrl (
    .clk(clk), .arstN(arstN), .rstReq(rstReq), .chanWe(chanWe),
    .chanPdIn(chanPdIn), .convEdge(convEdge), .stopped(stopped),
    .hiccup(hiccup), .pdSync(pdSync), .recDone(recDone), .strobe(strobe),
    .refEn(refEn), .clkEn(clkEn), .chanEn(chanEn), .ready(ready),
    .zeroData(zeroData)
  );

  p_zero_when_idle_r9: assert property (@(posedge clk) disable iff (!arstN)
    !ready |-> zeroData);

endmodule

// File: tb/tb_pwrseq_top.sv
`timescale 1ns/1ps
module tb_pwrseq_top;
  localparam int NCH = 8;

  logic clk = 1'b0;
  logic arstN, rstReq, pdPin, convClk, chanWe;
  logic [NCH-1:0] chanPdIn;
  logic refEn, clkEn, ready, zeroData;
  logic [NCH-1:0] chanEn;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  bit convRun = 1;
  int halfNs  = 50;
  int pauseNs = 0;

  pwrseq_top #(.NUM_CH(NCH)) dut (
    .clk(clk), .arstN(arstN), .rstReq(rstReq), .pdPin(pdPin),
    .convClk(convClk), .chanWe(chanWe), .chanPdIn(chanPdIn),
    .refEn(refEn), .clkEn(clkEn), .chanEn(chanEn), .ready(ready),
    .zeroData(zeroData)
  );

  always #10 clk = ~clk;

  initial begin
    convClk = 1'b0;
    forever begin
      if (!convRun) wait (convRun);
      #(halfNs) convClk = 1'b1;
      #(halfNs) convClk = 1'b0;
      if (pauseNs > 0) begin
        #(pauseNs);
        pauseNs = 0;
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset();
    arstN = 0; rstReq = 0; pdPin = 0; chanWe = 0; chanPdIn = '0;
    cyc(3);
    chk("R10 ready", ready, 0);
    chk("R10 zeroData", zeroData, 1);
    chk("R10 refEn", refEn, 1);
    chk("R10 chanEn", chanEn, 8'hFF);
    arstN = 1;
  endtask

  task automatic testPowerUp();
    cyc(24900);
    chk("R5 ready before full interval", ready, 0);
    chk("R9 zeroData while not ready", zeroData, 1);
    cyc(200);
    chk("R5 ready after full interval", ready, 1);
    chk("R9 zeroData when ready", zeroData, 0);
    chk("R5 clkEn on", clkEn, 1);
  endtask

  task automatic testChanMask();
    chanPdIn = 8'h05; chanWe = 1;
    cyc(1);
    chanWe = 0; chanPdIn = '0;
    chk("R7 chanEn masked", chanEn, 8'hFA);
    chk("R7 ready kept", ready, 1);
  endtask

  task automatic testFuncReset();
    rstReq = 1;
    cyc(3);
    chk("R8 zeroData in reset", zeroData, 1);
    chk("R8 clkEn unaffected", clkEn, 1);
    chk("R8 ready unaffected", ready, 1);
    chk("R8 channel register cleared", chanEn, 8'hFF);
    rstReq = 0;
    cyc(1);
    chk("R9 zeroData after reset", zeroData, 0);
  endtask

  task automatic testShortStop();
    bit fell = 0;
    pauseNs = 140;
    for (int i = 0; i < 80; i++) begin
      cyc(1);
      if (!ready) begin fell = 1; break; end
    end
    chk("R3 ready drops on hiccup", fell, 1);
    chk("R3 clkEn stays on", clkEn, 1);
    cyc(450);
    chk("R3 ready low inside short recovery", ready, 0);
    cyc(100);
    chk("R3 ready after short recovery", ready, 1);
  endtask

  task automatic testLongStop();
    convRun = 0;
    cyc(40);
    chk("R1 ready off", ready, 0);
    chk("R1 clkEn off", clkEn, 0);
    chk("R1 refEn on", refEn, 1);
    chk("R1 chanEn off", chanEn, 0);
    cyc(1000);
    chk("R1 still partial", clkEn, 0);
    convRun = 1;
    cyc(4900);
    chk("R4 ready low inside long recovery", ready, 0);
    chk("R4 clkEn back", clkEn, 1);
    cyc(200);
    chk("R4 ready after long recovery", ready, 1);
  endtask

  task automatic testSlowClock();
    bit sawReady = 0;
    halfNs = 200;
    cyc(100);
    for (int i = 0; i < 6000; i++) begin
      cyc(1);
      if (ready) sawReady = 1;
    end
    chk("R2 slow clock keeps ready low", sawReady, 0);
    halfNs = 50;
    cyc(5200);
    chk("R2 ready after clock speeds up", ready, 1);
  endtask

  task automatic testPdOverride();
    convRun = 0;
    cyc(40);
    convRun = 1;
    cyc(1000);
    pdPin = 1;
    cyc(5);
    chk("R5 refEn off", refEn, 0);
    chk("R5 clkEn off", clkEn, 0);
    chk("R5 chanEn off", chanEn, 0);
    chk("R5 zeroData on", zeroData, 1);
    cyc(100);
    pdPin = 0;
    cyc(5200);
    chk("R6 long recovery cancelled", ready, 0);
    cyc(19600);
    chk("R6 ready low before full interval", ready, 0);
    cyc(400);
    chk("R6 ready after full interval", ready, 1);
  endtask

  initial begin
    testReset();
    testPowerUp();
    testChanMask();
    testFuncReset();
    testShortStop();
    testLongStop();
    testSlowClock();
    testPdOverride();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule